// File: doc/BRIEF.md
# Call/Return Stack Frame Sequencer

This block performs the memory side of four stack operations: push, pop, subroutine call and subroutine return. It holds the stack pointer, the frame pointer and the program counter, and it reaches a single-port, word-addressed memory through one access port. The stack grows toward lower addresses. A push stores a word and then moves the pointer down. A pop moves the pointer up and then reads.

A call saves two words on the stack: the return address, which is the current instruction address plus one, and the caller's frame pointer. The frame pointer then takes the new stack pointer, and the program counter takes the branch target. A return reverses this. It drops the stack pointer back to the frame pointer, pops the saved frame pointer, and then pops the return address into the program counter.

Each memory access occupies one state and stays there until the memory signals ready. A one-cycle done pulse ends every operation. The block takes a new command only while it is idle. A command that arrives while it is busy is dropped.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset, sp_o and sf_o equal the TOP_OF_STACK parameter, pc_o is zero, and busy, done, mem_we and mem_re are all low.
- R2: A push (cmd_op 0) writes push_data to the address held in the stack pointer and then decrements the stack pointer by one.
- R3: A pop (cmd_op 1) increments the stack pointer by one, reads the word at the new address and presents it on pop_data. The stack pointer moves even when the caller discards the data.
- R4: A call (cmd_op 2) writes cur_pc+1 at the stack pointer and then writes the old frame pointer one word below it. The stack pointer ends two below its start, the frame pointer equals the final stack pointer, and pc_o equals call_target.
- R5: A return (cmd_op 3) sets the stack pointer to the frame pointer and then performs two pops. The first pop reads the word at frame pointer + 1 into the frame pointer. The second reads the word at frame pointer + 2 into pc_o. The stack pointer ends at the old frame pointer + 2.
- R6: A call followed by its matching return restores the stack pointer and the frame pointer exactly and leaves pc_o at the call's cur_pc+1. This also holds for calls nested two levels deep.
- R7: Each access holds mem_addr, mem_we and mem_re steady until a cycle with mem_rdy high. mem_we and mem_re are never high together.
- R8: done is high for exactly one cycle, in the cycle after the last access of the operation completes.
- R9: A command is taken only while busy is low. A command presented while busy is high has no effect on the pointers, the program counter or the memory, and it is not queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| push_data | input | DATA_W | Word to push |
| call_target | input | DATA_W | Branch target of a call |
| cur_pc | input | DATA_W | Address of the calling instruction |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory completes the current access |
| mem_addr | output | DATA_W | Word address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| pop_data | output | DATA_W | Word read by the last pop |
| pc_o | output | DATA_W | Program counter |
| sp_o | output | DATA_W | Stack pointer |
| sf_o | output | DATA_W | Frame pointer |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with DATA_W at 64 and TOP_OF_STACK at 200. With these values the whole stack fits in a 256-word model memory that is indexed by the low address bits. Random call depths of up to eight frames, each holding local pushes, therefore stay inside that memory while the pointers keep their full width. The ready line is randomly withheld for about one cycle in four, and it can be held low on purpose. This exercises the stall paths and gives the bench a wide window in which to present commands while the block is busy.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } sfs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_PUSH_WR    = 3'd1,
    ST_POP_RD     = 3'd2,
    ST_CALL_LINK  = 3'd3,
    ST_CALL_FRAME = 3'd4,
    ST_RET_FRAME  = 3'd5,
    ST_RET_LINK   = 3'd6
  } sfs_state_e;

  function automatic logic state_is_write(sfs_state_e s);
    return (s == ST_PUSH_WR) || (s == ST_CALL_LINK) || (s == ST_CALL_FRAME);
  endfunction

  function automatic logic state_is_read(sfs_state_e s);
    return (s == ST_POP_RD) || (s == ST_RET_FRAME) || (s == ST_RET_LINK);
  endfunction

  function automatic logic state_is_last(sfs_state_e s);
    return (s == ST_PUSH_WR) || (s == ST_POP_RD) ||
           (s == ST_CALL_FRAME) || (s == ST_RET_LINK);
  endfunction
endpackage

// File: rtl/sfs_fsm.sv
module sfs_fsm
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       mem_rdy,
  output sfs_state_e state,
  output logic       busy,
  output logic       accept,
  output logic       step_fire,
  output logic       seq_end,
  output logic       done
);
  sfs_state_e state_q, state_d;

  assign state     = state_q;
  assign busy      = (state_q != ST_IDLE);
  assign accept    = cmd_valid && (state_q == ST_IDLE);
  assign step_fire = busy && mem_rdy;
  assign seq_end   = step_fire && state_is_last(state_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          case (sfs_op_e'(cmd_op))
            OP_PUSH: state_d = ST_PUSH_WR;
            OP_POP:  state_d = ST_POP_RD;
            OP_CALL: state_d = ST_CALL_LINK;
            default: state_d = ST_RET_FRAME;
          endcase
        end
      end
      ST_CALL_LINK: if (mem_rdy) state_d = ST_CALL_FRAME;
      ST_RET_FRAME: if (mem_rdy) state_d = ST_RET_LINK;
      default:      if (mem_rdy) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= seq_end;
    end
  end
endmodule

// File: rtl/sfs_ptr_file.sv
module sfs_ptr_file
  import sfs_pkg::*;
#(
  parameter int unsigned       W            = 64,
  parameter logic [W-1:0]      TOP_OF_STACK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [1:0]   cmd_op,
  input  sfs_state_e   state,
  input  logic         step_fire,
  input  logic [W-1:0] push_data,
  input  logic [W-1:0] call_target,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] sp,
  output logic [W-1:0] sf,
  output logic [W-1:0] pc,
  output logic [W-1:0] pop_data,
  output logic [W-1:0] opnd_q,
  output logic [W-1:0] link_q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] tgt_q;

  function automatic logic [W-1:0] sp_after_push(logic [W-1:0] p);
    return p - ONE;
  endfunction

  function automatic logic [W-1:0] sp_before_pop(logic [W-1:0] p);
    return p + ONE;
  endfunction

  function automatic logic [W-1:0] link_of(logic [W-1:0] p);
    return p + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp       <= TOP_OF_STACK;
      sf       <= TOP_OF_STACK;
      pc       <= '0;
      pop_data <= '0;
      opnd_q   <= '0;
      link_q   <= '0;
      tgt_q    <= '0;
    end else if (accept) begin
      case (sfs_op_e'(cmd_op))
        OP_PUSH: opnd_q <= push_data;
        OP_POP:  sp     <= sp_before_pop(sp);
        OP_CALL: begin
          link_q <= link_of(cur_pc);
          tgt_q  <= call_target;
        end
        default: sp <= sp_before_pop(sf);
      endcase
    end else if (step_fire) begin
      case (state)
        ST_PUSH_WR:   sp <= sp_after_push(sp);
        ST_POP_RD:    pop_data <= mem_rdata;
        ST_CALL_LINK: sp <= sp_after_push(sp);
        ST_CALL_FRAME: begin
          sp <= sp_after_push(sp);
          sf <= sp_after_push(sp);
          pc <= tgt_q;
        end
        ST_RET_FRAME: begin
          sf <= mem_rdata;
          sp <= sp_before_pop(sp);
        end
        ST_RET_LINK:  pc <= mem_rdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sfs_mem_port.sv
module sfs_mem_port
  import sfs_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  sfs_state_e   state,
  input  logic [W-1:0] sp,
  input  logic [W-1:0] sf,
  input  logic [W-1:0] opnd_q,
  input  logic [W-1:0] link_q,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic         mem_re
);
  assign mem_addr = sp;
  assign mem_we   = state_is_write(state);
  assign mem_re   = state_is_read(state);

  always_comb begin
    case (state)
      ST_PUSH_WR:    mem_wdata = opnd_q;
      ST_CALL_LINK:  mem_wdata = link_q;
      ST_CALL_FRAME: mem_wdata = sf;
      default:       mem_wdata = '0;
    endcase
  end
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import sfs_pkg::*;
#(
  parameter int unsigned            DATA_W       = 64,
  parameter logic [DATA_W-1:0]      TOP_OF_STACK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] call_target,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] pop_data,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] sf_o,
  output logic              busy,
  output logic              done
);
  sfs_state_e        state;
  logic              accept;
  logic              step_fire;
  logic              seq_end;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] link_q;

  sfs_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .mem_rdy   (mem_rdy),
    .state     (state),
    .busy      (busy),
    .accept    (accept),
    .step_fire (step_fire),
    .seq_end   (seq_end),
    .done      (done)
  );

  sfs_ptr_file #(.W(DATA_W), .TOP_OF_STACK(TOP_OF_STACK)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .cmd_op      (cmd_op),
    .state       (state),
    .step_fire   (step_fire),
    .push_data   (push_data),
    .call_target (call_target),
    .cur_pc      (cur_pc),
    .mem_rdata   (mem_rdata),
    .sp          (sp_o),
    .sf          (sf_o),
    .pc          (pc_o),
    .pop_data    (pop_data),
    .opnd_q      (opnd_q),
    .link_q      (link_q)
  );

  sfs_mem_port #(.W(DATA_W)) u_port (
    .state     (state),
    .sp        (sp_o),
    .sf        (sf_o),
    .opnd_q    (opnd_q),
    .link_q    (link_q),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [1:0]   cmd_op,
  input logic         busy,
  input logic         mem_we,
  input logic         mem_re,
  input logic         mem_rdy,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] sp_o,
  input logic [W-1:0] sf_o,
  input logic         done,
  input logic         step_fire,
  input logic         seq_end
);
  assert_excl_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && !mem_rdy |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_re));

  assert_push_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 2'd0 |=> mem_we && mem_addr == $past(sp_o));

  assert_pop_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 2'd1 |=> mem_re && mem_addr == $past(sp_o) + W'(1));

  assert_ret_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 2'd3 |=> mem_re && mem_addr == $past(sf_o) + W'(1));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> done && !busy);

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step_fire |=> $stable(sp_o) && $stable(sf_o));
endmodule

bind stack_frame_seq sfs_checker #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_rdy   (mem_rdy),
  .mem_addr  (mem_addr),
  .sp_o      (sp_o),
  .sf_o      (sf_o),
  .done      (done),
  .step_fire (step_fire),
  .seq_end   (seq_end)
);

// File: tb/stack_frame_seq_tb_top.sv
`timescale 1ns/1ps
module stack_frame_seq_tb_top;
  localparam int unsigned W   = 64;
  localparam logic [W-1:0] TOS = 64'd200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'd0;
  logic [W-1:0] push_data = '0;
  logic [W-1:0] call_target = '0;
  logic [W-1:0] cur_pc = '0;
  logic [W-1:0] mem_rdata;
  logic         mem_rdy = 1'b0;
  logic [W-1:0] mem_addr, mem_wdata, pop_data, pc_o, sp_o, sf_o;
  logic         mem_we, mem_re, busy, done;

  logic [W-1:0] tmem [0:255];
  logic [W-1:0] mmem [0:255];
  logic [W-1:0] m_sp, m_sf, m_pc;
  logic         stall = 1'b0;
  int           checks = 0;
  int           errors = 0;
  int           locals [0:15];
  int           depth = 0;

  always #10 clk = ~clk;

  stack_frame_seq #(.DATA_W(W), .TOP_OF_STACK(TOS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .push_data(push_data), .call_target(call_target), .cur_pc(cur_pc),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .pop_data(pop_data), .pc_o(pc_o), .sp_o(sp_o), .sf_o(sf_o),
    .busy(busy), .done(done)
  );

  assign mem_rdata = tmem[mem_addr[7:0]];

  always @(posedge clk) if (mem_we && mem_rdy) tmem[mem_addr[7:0]] <= mem_wdata;

  always @(negedge clk) mem_rdy <= stall ? 1'b0 : ($urandom_range(0, 3) != 0);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] link_addr(logic [W-1:0] p);
    return p + 64'd1;
  endfunction

  task automatic model_op(int op, logic [W-1:0] d, logic [W-1:0] tgt, logic [W-1:0] cpc,
                          output logic [W-1:0] exp_pop);
    exp_pop = '0;
    case (op)
      0: begin mmem[m_sp[7:0]] = d; m_sp = m_sp - 1; end
      1: begin m_sp = m_sp + 1; exp_pop = mmem[m_sp[7:0]]; end
      2: begin
        mmem[m_sp[7:0]] = link_addr(cpc);
        mmem[m_sp[7:0] - 8'd1] = m_sf;
        m_sp = m_sp - 2; m_sf = m_sp; m_pc = tgt;
      end
      default: begin
        m_sp = m_sf + 1; m_sf = mmem[m_sp[7:0]];
        m_sp = m_sp + 1; m_pc = mmem[m_sp[7:0]];
      end
    endcase
  endtask

  task automatic wait_done(string req);
    int cyc = 0;
    while (done !== 1'b1 && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(req, {63'd0, done}, 64'd1);
    @(negedge clk);
    chk("R8 done single cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic run_op(int op, logic [W-1:0] d, logic [W-1:0] tgt, logic [W-1:0] cpc, string req);
    logic [W-1:0] ep;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); push_data = d; call_target = tgt; cur_pc = cpc;
    @(negedge clk);
    cmd_valid = 1'b0; push_data = '1; call_target = '1; cur_pc = '1;
    checks++;
    if (busy !== 1'b1) begin errors++; $display("FAIL R9 busy after accept actual=%0b expected=1", busy); end
    wait_done("R8 done seen");
    model_op(op, d, tgt, cpc, ep);
    chk({req, " sp"}, sp_o, m_sp);
    chk({req, " sf"}, sf_o, m_sf);
    chk({req, " pc"}, pc_o, m_pc);
    if (op == 1) chk({req, " pop_data"}, pop_data, ep);
    if (op == 0 || op == 2) begin
      chk({req, " mem top"}, tmem[m_sp[7:0] + 8'd1], mmem[m_sp[7:0] + 8'd1]);
      if (op == 2) chk({req, " mem next"}, tmem[m_sp[7:0] + 8'd2], mmem[m_sp[7:0] + 8'd2]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] s_sp, s_sf, s_pc0, s_pc1;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin tmem[i] = '0; mmem[i] = '0; end
    for (int i = 0; i < 16; i++) locals[i] = 0;
    m_sp = TOS; m_sf = TOS; m_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp_o, TOS);
    chk("R1 sf", sf_o, TOS);
    chk("R1 pc", pc_o, '0);
    chk("R1 strobes", {60'd0, busy, done, mem_we, mem_re}, '0);

    // R2 / R3 directed
    run_op(0, 64'hAAAA_5555_0000_FFFF, 0, 0, "R2 push");
    run_op(0, 64'h1234_5678_9ABC_DEF0, 0, 0, "R2 push");
    run_op(1, 0, 0, 0, "R3 pop");
    run_op(1, 0, 0, 0, "R3 pop discard");

    // R4 / R5 / R6 nested two levels
    s_sp = m_sp; s_sf = m_sf;
    s_pc0 = 64'h0000_0000_0000_0100;
    run_op(2, 0, 64'h400, s_pc0, "R4 call outer");
    run_op(0, 64'hDEAD, 0, 0, "R2 push in frame");
    s_pc1 = 64'h0000_0000_0000_0410;
    run_op(2, 0, 64'h800, s_pc1, "R4 call inner");
    run_op(0, 64'hBEEF, 0, 0, "R2 push in inner");
    run_op(3, 0, 0, 0, "R5 return inner");
    chk("R6 inner pc", pc_o, s_pc1 + 64'd1);
    run_op(3, 0, 0, 0, "R5 return outer");
    chk("R6 sp restored", sp_o, s_sp);
    chk("R6 sf restored", sf_o, s_sf);
    chk("R6 pc restored", pc_o, s_pc0 + 64'd1);

    // R9 command while busy is dropped; R7 stall holds
    begin
      logic [W-1:0] ep;
      @(negedge clk);
      stall = 1'b1;
      cmd_valid = 1'b1; cmd_op = 2'd0; push_data = 64'h77;
      @(negedge clk);
      cmd_op = 2'd1;
      repeat (3) begin
        @(negedge clk);
        chk("R9 sp held while busy", sp_o, m_sp);
        chk("R7 stalled write at sp", mem_addr, m_sp);
      end
      cmd_valid = 1'b0;
      stall = 1'b0;
      wait_done("R8 done after stall");
      model_op(0, 64'h77, 0, 0, ep);
      chk("R9 only push took effect", sp_o, m_sp);
      chk("R9 pushed word", tmem[m_sp[7:0] + 8'd1], 64'h77);
      repeat (4) @(negedge clk);
      chk("R9 not queued", sp_o, m_sp);
      locals[0] = locals[0] + 1;
    end

    // random mix
    for (int n = 0; n < 300; n++) begin
      int sel = $urandom_range(0, 3);
      logic [W-1:0] rd = {$urandom, $urandom};
      if (sel == 1 && locals[depth] == 0) sel = 0;
      if (sel == 3 && depth == 0) sel = 2;
      if ((sel == 0 || sel == 2) && (m_sp < 64'd40 || depth >= 8)) sel = (depth > 0) ? 3 : 1;
      if (sel == 1 && locals[depth] == 0) sel = 3;
      case (sel)
        0: begin run_op(0, rd, 0, 0, "R2 random push"); locals[depth]++; end
        1: begin run_op(1, 0, 0, 0, "R3 random pop"); locals[depth]--; end
        2: begin depth++; locals[depth] = 0;
                 run_op(2, 0, {$urandom, $urandom}, rd, "R4 random call"); end
        default: begin run_op(3, 0, 0, 0, "R5 random return"); depth--; end
      endcase
    end
    while (depth > 0) begin run_op(3, 0, 0, 0, "R6 unwind return"); depth--; end
    chk("R6 final sf", sf_o, TOS);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule